// File: doc/BRIEF.md
# Dual-Group Interrupt Status and Mask Unit

This unit gathers interrupt events for a multi-channel DMA engine into two independent groups: a normal group and an error group. Each group has a 32-bit sticky status register and a 32-bit mask register. In the mask, a 1 means the bit is masked and a 0 means it is unmasked. Event pulses from the channel logic set status bits. Software clears status bits with write-one-to-clear writes.

Software changes a mask only through two write ports per group. One port unmasks the bits it is given and the other masks them. A direct write to a mask register has no effect. The unit drives one registered, level-sensitive interrupt line. That line is high when either group holds a status bit whose mask bit is clear.

The register interface is a single-cycle write strobe with a 3-bit word index. Read data is combinational from the index.

Top module: `irq_dual_group`

## Requirements
- R1: A write to a status register (word index 0 for the normal group, 4 for the error group) clears each status bit written as 1. Bits written as 0 keep their value.
- R2: A write to an unmask port (index 2 for normal, 6 for error) clears the mask bits written as 1. Other mask bits are unchanged.
- R3: A write to a mask-set port (index 3 for normal, 7 for error) sets the mask bits written as 1. Other mask bits are unchanged.
- R4: A write to a mask register itself (index 1 for normal, 5 for error) leaves that register unchanged.
- R5: Reset clears both status registers. It loads the normal mask with 0x07FFFFFF and the error mask with 0xFFFFFFFF. The interrupt output is 0 after reset.
- R6: At every clock edge, the interrupt output is loaded with the OR of two terms: any bit of (normal status AND NOT normal mask), and any bit of (error status AND NOT error mask). It therefore follows a status or mask change one cycle later.
- R7: If an event sets a status bit in the same cycle that software clears that bit, the bit ends up set.
- R8: A descriptor-done pulse on channel i sets normal status bit i. A data-fetch-error pulse on channel i sets normal status bit 12+i. A frame-sync pulse sets normal status bit 27.
- R9: Bit j of the error event vector sets error status bit j.
- R10: Reads of the four unmask and mask-set ports return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| evt_done | input | 6 | Per-channel descriptor-done pulses |
| evt_fetch_err | input | 6 | Per-channel data-fetch-error pulses |
| evt_frame_sync | input | 1 | Frame-sync pulse |
| evt_err | input | 32 | Error group event pulses, one per status bit |
| irq | output | 1 | Registered level interrupt |

## Verification
Two functions can act on one status bit in the same cycle: a hardware event that sets the bit, and a software write-one-to-clear. The bench provokes this by driving an error event together with a status write whose data covers that event bit. The same write data also covers a second, already pending bit that has no event. The judgement is that the event bit stays set while the other bit is cleared. The interrupt level one cycle later must match the bench's own model of status and mask.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

  // Word index of each register; software decodes these values.
  typedef enum logic [2:0] {
    RA_NSTAT  = 3'd0,
    RA_NMASK  = 3'd1,
    RA_NUNMSK = 3'd2,
    RA_NMSK   = 3'd3,
    RA_ESTAT  = 3'd4,
    RA_EMASK  = 3'd5,
    RA_EUNMSK = 3'd6,
    RA_EMSK   = 3'd7
  } irqg_reg_e;

  // Write strobes that the decoder hands to one group.
  typedef struct packed {
    logic stat_wr;
    logic unmask_wr;
    logic mask_wr;
    logic mask_direct;
  } grp_strobe_t;

endpackage

// File: rtl/irqg_rst_sync.sv
module irqg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irqg_group.sv
module irqg_group
  import irqg_pkg::*;
#(
  parameter int           W        = 32,
  parameter logic [W-1:0] MASK_RST = '1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  grp_strobe_t strb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);

  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] mask_q, mask_d;
  logic         stat_en, mask_en;
  logic [W-1:0] clr_vec;

  // Next state: software clear first, then the hardware set, so the set wins.
  always_comb begin
    clr_vec = strb.stat_wr ? wdata : '0;
    stat_d  = (stat_q & ~clr_vec) | set_i;
    stat_en = strb.stat_wr | (|set_i);
    mask_d  = mask_q;
    if (strb.unmask_wr) mask_d = mask_q & ~wdata;
    if (strb.mask_wr)   mask_d = mask_q | wdata;
    mask_en = strb.unmask_wr | strb.mask_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & ~mask_q);

  p_w1c_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.stat_wr |=> ((stat_q & $past(wdata) & ~$past(set_i)) == '0));

  p_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.stat_wr |=> ((stat_q & $past(stat_q & ~wdata)) == $past(stat_q & ~wdata)));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  p_unmask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.unmask_wr |=> ((mask_q & $past(wdata)) == '0));

  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.mask_wr |=> ((mask_q & $past(wdata)) == $past(wdata)));

  p_mask_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.mask_direct |=> $stable(mask_q));

endmodule

// File: rtl/irqg_decode.sv
module irqg_decode
  import irqg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] nstat,
  input  logic [W-1:0] nmask,
  input  logic [W-1:0] estat,
  input  logic [W-1:0] emask,
  output grp_strobe_t  norm_s,
  output grp_strobe_t  err_s,
  output logic [W-1:0] rdata
);

  irqg_reg_e ra;

  always_comb begin
    ra     = irqg_reg_e'(reg_addr);
    norm_s = '0;
    err_s  = '0;
    rdata  = '0;
    case (ra)
      RA_NSTAT:  begin norm_s.stat_wr     = reg_wr; rdata = nstat; end
      RA_NMASK:  begin norm_s.mask_direct = reg_wr; rdata = nmask; end
      RA_NUNMSK: norm_s.unmask_wr = reg_wr;
      RA_NMSK:   norm_s.mask_wr   = reg_wr;
      RA_ESTAT:  begin err_s.stat_wr      = reg_wr; rdata = estat; end
      RA_EMASK:  begin err_s.mask_direct  = reg_wr; rdata = emask; end
      RA_EUNMSK: err_s.unmask_wr = reg_wr;
      RA_EMSK:   err_s.mask_wr   = reg_wr;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_dual_group.sv
module irq_dual_group
  import irqg_pkg::*;
#(
  parameter int           DATA_W        = 32,
  parameter int           NUM_CH        = 6,
  parameter int           DONE_BASE     = 0,
  parameter int           FETCH_BASE    = 12,
  parameter int           SYNC_BIT      = 27,
  parameter logic [31:0]  NORM_MASK_RST = 32'h07FF_FFFF,
  parameter logic [31:0]  ERR_MASK_RST  = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] evt_done,
  input  logic [NUM_CH-1:0] evt_fetch_err,
  input  logic              evt_frame_sync,
  input  logic [DATA_W-1:0] evt_err,
  output logic              irq
);

  localparam logic [DATA_W-1:0] NMASK_INIT = DATA_W'(NORM_MASK_RST);
  localparam logic [DATA_W-1:0] EMASK_INIT = DATA_W'(ERR_MASK_RST);

  logic              rst_i_n;
  grp_strobe_t       norm_s, err_s;
  logic [DATA_W-1:0] norm_set;
  logic [DATA_W-1:0] nstat, nmask, estat, emask;
  logic              norm_pend, err_pend;
  logic              irq_q, irq_d;

  irqg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Place channel events on their normal-group status bits.
  always_comb begin
    norm_set = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      norm_set[DONE_BASE + i]  = evt_done[i];
      norm_set[FETCH_BASE + i] = evt_fetch_err[i];
    end
    norm_set[SYNC_BIT] = evt_frame_sync;
  end

  irqg_decode #(.W(DATA_W)) u_dec (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .nstat    (nstat),
    .nmask    (nmask),
    .estat    (estat),
    .emask    (emask),
    .norm_s   (norm_s),
    .err_s    (err_s),
    .rdata    (reg_rdata)
  );

  irqg_group #(.W(DATA_W), .MASK_RST(NMASK_INIT)) u_norm (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .strb   (norm_s),
    .wdata  (reg_wdata),
    .set_i  (norm_set),
    .stat_o (nstat),
    .mask_o (nmask),
    .pend_o (norm_pend)
  );

  irqg_group #(.W(DATA_W), .MASK_RST(EMASK_INIT)) u_err (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .strb   (err_s),
    .wdata  (reg_wdata),
    .set_i  (evt_err),
    .stat_o (estat),
    .mask_o (emask),
    .pend_o (err_pend)
  );

  always_comb begin
    irq_d = norm_pend | err_pend;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (norm_pend || err_pend) |=> irq);

  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(norm_pend || err_pend) |=> !irq);

  p_sync_bit_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    evt_frame_sync |=> nstat[SYNC_BIT]);

  p_err_evt_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|evt_err) |=> ((estat & $past(evt_err)) == $past(evt_err)));

endmodule

// File: tb/irq_dual_group_bench.sv
module irq_dual_group_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [5:0]  evt_done;
  logic [5:0]  evt_fetch_err;
  logic        evt_frame_sync;
  logic [31:0] evt_err;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] m_nst, m_nmk, m_est, m_emk;
  logic        m_irq;

  always #4 clk = ~clk;

  irq_dual_group u_irq_dual_group (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .evt_done       (evt_done),
    .evt_fetch_err  (evt_fetch_err),
    .evt_frame_sync (evt_frame_sync),
    .evt_err        (evt_err),
    .irq            (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  // One cycle of stimulus, entered and left on a falling edge; the model
  // follows the requirements and the interrupt level is checked after it.
  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                      input logic [31:0] e, input logic [5:0] dn,
                      input logic [5:0] fe, input logic fs);
    logic [31:0] nset;
    reg_wr = w; reg_addr = a; reg_wdata = d;
    evt_err = e; evt_done = dn; evt_fetch_err = fe; evt_frame_sync = fs;
    nset = 32'(dn) | (32'(fe) << 12) | (32'(fs) << 27);
    m_irq = (|(m_nst & ~m_nmk)) | (|(m_est & ~m_emk));
    if (w) begin
      case (a)
        3'd0: m_nst = m_nst & ~d;
        3'd2: m_nmk = m_nmk & ~d;
        3'd3: m_nmk = m_nmk | d;
        3'd4: m_est = m_est & ~d;
        3'd6: m_emk = m_emk & ~d;
        3'd7: m_emk = m_emk | d;
        default: ;
      endcase
    end
    m_nst = m_nst | nset;
    m_est = m_est | e;
    @(negedge clk);
    reg_wr = 1'b0; evt_err = '0; evt_done = '0; evt_fetch_err = '0; evt_frame_sync = 1'b0;
    chk("R6 irq", 32'(irq), 32'(m_irq));
  endtask

  task automatic idle();
    step(1'b0, 3'd0, 32'h0, 32'h0, 6'h0, 6'h0, 1'b0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1'b1, a, d, 32'h0, 6'h0, 6'h0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt_err = '0; evt_done = '0; evt_fetch_err = '0; evt_frame_sync = 1'b0;
    m_nst = '0; m_est = '0; m_nmk = 32'h07FF_FFFF; m_emk = 32'hFFFF_FFFF; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 reset state, R10 port reads
    chk("R5 irq", 32'(irq), 32'h0);
    rdchk(3'd0, 32'h0, "R5 nstat");
    rdchk(3'd1, 32'h07FF_FFFF, "R5 nmask");
    rdchk(3'd4, 32'h0, "R5 estat");
    rdchk(3'd5, 32'hFFFF_FFFF, "R5 emask");
    for (int a = 2; a < 8; a++)
      if (a == 2 || a == 3 || a == 6 || a == 7) rdchk(3'(a), 32'h0, "R10 port read");

    // Error group: sweep every bit
    for (int j = 0; j < 32; j++) begin
      step(1'b0, 3'd0, 32'h0, 32'h1 << j, 6'h0, 6'h0, 1'b0);
      rdchk(3'd4, m_est, "R9 estat");
      idle();
      wr(3'd5, 32'h0);
      rdchk(3'd5, m_emk, "R4 emask direct write");
      wr(3'd6, 32'h1 << j);
      rdchk(3'd5, m_emk, "R2 emask unmask");
      rdchk(3'd6, 32'h0, "R10 eunmask read");
      idle();
      wr(3'd7, 32'h1 << j);
      rdchk(3'd5, m_emk, "R3 emask set");
      rdchk(3'd7, 32'h0, "R10 emask-set read");
      idle();
      wr(3'd4, 32'h0);
      rdchk(3'd4, m_est, "R1 write zero keeps");
      wr(3'd4, 32'h1 << j);
      rdchk(3'd4, m_est, "R1 w1c");
    end

    // Normal group channel events
    for (int c = 0; c < 6; c++) begin
      step(1'b0, 3'd0, 32'h0, 32'h0, 6'h1 << c, 6'h0, 1'b0);
      rdchk(3'd0, m_nst, "R8 done bit");
      chk("R8 done pos", m_nst, 32'h1 << c);
      step(1'b0, 3'd0, 32'h0, 32'h0, 6'h0, 6'h1 << c, 1'b0);
      rdchk(3'd0, m_nst, "R8 fetch bit");
      idle();
      wr(3'd0, 32'hFFFF_FFFF);
      rdchk(3'd0, 32'h0, "R1 clear all");
    end

    // Frame sync is unmasked from reset
    step(1'b0, 3'd0, 32'h0, 32'h0, 6'h0, 6'h0, 1'b1);
    rdchk(3'd0, 32'h0800_0000, "R8 frame sync bit 27");
    idle();
    chk("R5 bit27 unmasked irq", 32'(irq), 32'h1);
    wr(3'd1, 32'hFFFF_FFFF);
    rdchk(3'd1, 32'h07FF_FFFF, "R4 nmask direct write");
    wr(3'd3, 32'h0800_0000);
    rdchk(3'd1, m_nmk, "R3 nmask set");
    idle();
    wr(3'd2, 32'h0000_F00F);
    rdchk(3'd1, m_nmk, "R2 nmask unmask");
    rdchk(3'd2, 32'h0, "R10 nunmask read");
    rdchk(3'd3, 32'h0, "R10 nmask-set read");
    wr(3'd0, 32'h0800_0000);
    step(1'b0, 3'd0, 32'h0, 32'h0, 6'h2, 6'h0, 1'b0);
    idle();
    chk("R6 normal unmasked irq", 32'(irq), 32'h1);
    wr(3'd0, 32'h2);
    idle();

    // R7: set and clear in the same cycle
    wr(3'd6, 32'h0000_0208);
    step(1'b0, 3'd0, 32'h0, 32'h0000_0200, 6'h0, 6'h0, 1'b0);
    step(1'b1, 3'd4, 32'h0000_0208, 32'h0000_0008, 6'h0, 6'h0, 1'b0);
    rdchk(3'd4, 32'h0000_0008, "R7 set wins");
    idle();
    chk("R7 irq held by set bit", 32'(irq), 32'h1);
    step(1'b1, 3'd0, 32'h0000_0004, 32'h0, 6'h4, 6'h0, 1'b0);
    rdchk(3'd0, 32'h0000_0004, "R7 normal set wins");
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd0, 32'hFFFF_FFFF);
    idle();
    chk("R6 irq low after clears", 32'(irq), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule